// File: doc/BRIEF.md
# Video Memory Scan and Host Bus Arbiter

This block lets a single video RAM port serve two masters. Most of the time the display scan owns the port: the address is built from the current line number and the half-rate pixel column. The read data is caught in a pixel register, which feeds an 8-bit colour output. A host microcontroller can take over the port by pulling an active-low select. It may do so only while a timing generator asserts a microcontroller window. That window is a shortened form of the blanking interval, so a host write always finishes before the scan needs the memory again.

All RAM-side outputs are registered together, one clock after their inputs. A host request is latched on the clock edge where it is granted. The write strobe is a single clock pulse issued whenever the host presents a new address or data while granted. The pixel register is loaded on a falling edge of the half-rate pixel strobe, detected in the clock domain. The colour output reads as zero whenever display blank is high.

Top module: `vram_arbiter`

## Requirements
- R1: While reset is asserted, `ram_addr`, `ram_wdata`, `ram_we`, `grant`, `grant_err` and `pixel_out` are all zero.
- R2: When `host_sel_n` was high at a clock edge, after that edge `grant` is 0, `ram_wdata` is 0 and `ram_addr` equals the scan address sampled at that edge.
- R3: When `host_sel_n` was low and `mcu_win` was high at a clock edge, after that edge `grant` is 1 and `ram_addr`/`ram_wdata` equal the `host_addr`/`host_wdata` sampled at that edge.
- R4: When `host_sel_n` was low and `mcu_win` was low at a clock edge, the request is ignored. After that edge `grant` is 0, `ram_we` is 0, `ram_addr` is the scan address, and `grant_err` is 1 for that one cycle only.
- R5: `ram_we` is 1 for exactly one clock after each edge where the host is granted and either was not granted at the previous edge or presents an address or data different from the previously latched values. It is 0 otherwise.
- R6: The pixel register loads `ram_rdata` at a clock edge where `pix_strobe` is sampled low and was sampled high at the previous edge. At every other edge it holds its value.
- R7: `pixel_out` is 8'h00 whenever `disp_blank` is high (combinational, no tri-state). When `disp_blank` is low, `pixel_out` equals the pixel register.
- R8: The scan address is `line_idx * 320 + col_idx`, with a parameterised address width. Line 0, column 0 maps to 0, and line 239, column 319 maps to 76799.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_idx | input | 8 | Current scan line number |
| col_idx | input | 9 | Current half-rate pixel column |
| pix_strobe | input | 1 | Half-rate pixel strobe; its falling edge loads the pixel register |
| disp_blank | input | 1 | Display blank, high outside the visible area |
| mcu_win | input | 1 | Microcontroller access window, high when a host access may start |
| host_sel_n | input | 1 | Active-low host bus select |
| host_addr | input | 17 | Host write address |
| host_wdata | input | 8 | Host write data |
| ram_addr | output | 17 | Video RAM address |
| ram_wdata | output | 8 | Video RAM write data |
| ram_we | output | 1 | Video RAM write strobe, one clock per host write |
| ram_rdata | input | 8 | Video RAM read data |
| pixel_out | output | 8 | Colour value, zero during blank |
| grant | output | 1 | Host currently owns the RAM port |
| grant_err | output | 1 | Host select seen outside the access window |

## Verification
A stuck or wrong ownership bit shows on `ram_addr` and `grant` within one clock of the select changing. A missing or repeated write compare shows as an absent or extra `ram_we` pulse in the cycle after the host presents new data. A pixel register that loads on the wrong strobe edge, or fails to hold, differs on `pixel_out` from the first visible cycle after the strobe moves. A scan multiplier error shows on `ram_addr` one cycle after the line or column inputs change, and is most visible at the last line and column.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

  // Which master drives the RAM port in the current cycle
  typedef enum logic {
    BUS_SCAN = 1'b0,
    BUS_HOST = 1'b1
  } bus_owner_e;

  localparam int unsigned DATA_W_DEF = 8;

endpackage

// File: rtl/vram_rst_sync.sv
module vram_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/vram_scan_addr.sv
module vram_scan_addr #(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned LINE_W      = 8,
  parameter int unsigned COL_W       = 9,
  parameter int unsigned LINE_PIXELS = 320,
  parameter int unsigned LINES       = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_idx,
  input  logic [COL_W-1:0]  col_idx,
  output logic [ADDR_W-1:0] scan_addr
);

  localparam logic [ADDR_W-1:0] PITCH = ADDR_W'(LINE_PIXELS);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(LINE_PIXELS * LINES);

  logic [ADDR_W-1:0] scan_d;
  logic [ADDR_W-1:0] scan_q;

  always_comb begin
    scan_d = (ADDR_W'(line_idx) * PITCH) + ADDR_W'(col_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= '0;
    end else begin
      scan_q <= scan_d;
    end
  end

  assign scan_addr = scan_q;

  // R8
  scan_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ADDR_W'(line_idx) < ADDR_W'(LINES) && ADDR_W'(col_idx) < PITCH) |=> (scan_q < LIMIT));

endmodule

// File: rtl/vram_host_port.sv
module vram_host_port #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_sel_n,
  input  logic                    mcu_win,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [DATA_W-1:0]       host_wdata,
  output vram_arb_pkg::bus_owner_e owner,
  output logic [ADDR_W-1:0]       hold_addr,
  output logic [DATA_W-1:0]       hold_data,
  output logic                    wr_pulse,
  output logic                    req_err
);

  import vram_arb_pkg::*;

  logic              req;
  logic              grant_now;
  logic              changed;
  logic              grant_d, grant_q;
  logic              we_d, we_q;
  logic              err_d, err_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [DATA_W-1:0] data_d, data_q;

  // Next-state logic
  always_comb begin
    req       = ~host_sel_n;
    grant_now = req & mcu_win;
    changed   = (host_addr != addr_q) | (host_wdata != data_q);
    grant_d   = grant_now;
    err_d     = req & ~mcu_win;
    we_d      = grant_now & (~grant_q | changed);
    addr_d    = addr_q;
    data_d    = data_q;
    if (grant_now) begin
      addr_d = host_addr;
      data_d = host_wdata;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      grant_q <= grant_d;
      we_q    <= we_d;
      err_q   <= err_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign owner     = grant_q ? BUS_HOST : BUS_SCAN;
  assign hold_addr = addr_q;
  assign hold_data = data_q;
  assign wr_pulse  = we_q;
  assign req_err   = err_q;

  // R5
  we_only_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> grant_q);

  // R5
  we_on_grant_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_q) |-> we_q);

  // R4
  err_excludes_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_q && grant_q));

  // R4
  outside_window_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mcu_win) |=> (!grant_q && !we_q));

endmodule

// File: rtl/vram_pixel_reg.sv
module vram_pixel_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_strobe,
  input  logic              disp_blank,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] pixel_out
);

  logic              strb_q;
  logic              fall;
  logic [DATA_W-1:0] pix_d, pix_q;

  always_comb begin
    fall  = strb_q & ~pix_strobe;
    pix_d = fall ? ram_rdata : pix_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      pix_q  <= '0;
    end else begin
      strb_q <= pix_strobe;
      pix_q  <= pix_d;
    end
  end

  assign pixel_out = disp_blank ? '0 : pix_q;

  // R6
  pixel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb_q && !pix_strobe) |=> $stable(pix_q));

  // R6
  pixel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_q && !pix_strobe) |=> (pix_q == $past(ram_rdata)));

endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter #(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned LINE_W      = 8,
  parameter int unsigned COL_W       = 9,
  parameter int unsigned LINE_PIXELS = 320,
  parameter int unsigned LINES       = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_idx,
  input  logic [COL_W-1:0]  col_idx,
  input  logic              pix_strobe,
  input  logic              disp_blank,
  input  logic              mcu_win,
  input  logic              host_sel_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] pixel_out,
  output logic              grant,
  output logic              grant_err
);

  import vram_arb_pkg::*;

  logic              rst_sync_n;
  logic [ADDR_W-1:0] scan_addr;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  bus_owner_e        owner;
  logic              wr_pulse;
  logic              req_err;

  vram_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vram_scan_addr #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .COL_W(COL_W),
    .LINE_PIXELS(LINE_PIXELS), .LINES(LINES)
  ) u_scan (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .line_idx  (line_idx),
    .col_idx   (col_idx),
    .scan_addr (scan_addr)
  );

  vram_host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_sel_n (host_sel_n),
    .mcu_win    (mcu_win),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .owner      (owner),
    .hold_addr  (hold_addr),
    .hold_data  (hold_data),
    .wr_pulse   (wr_pulse),
    .req_err    (req_err)
  );

  vram_pixel_reg #(.DATA_W(DATA_W)) u_pix (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pix_strobe (pix_strobe),
    .disp_blank (disp_blank),
    .ram_rdata  (ram_rdata),
    .pixel_out  (pixel_out)
  );

  // Bus mux: scan path is fully disconnected while the host owns the port
  always_comb begin
    if (owner == BUS_HOST) begin
      ram_addr  = hold_addr;
      ram_wdata = hold_data;
    end else begin
      ram_addr  = scan_addr;
      ram_wdata = '0;
    end
  end

  assign ram_we    = wr_pulse;
  assign grant     = (owner == BUS_HOST);
  assign grant_err = req_err;

  // R2
  scan_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !grant |-> (ram_wdata == '0 && !ram_we));

  // R7
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    disp_blank |-> (pixel_out == '0));

endmodule

// File: tb/test_vram_arbiter.sv
`timescale 1ns/1ps
module test_vram_arbiter;

  localparam int ADDR_W = 17;
  localparam int DATA_W = 8;

  logic              clk;
  logic              rst_n;
  logic [7:0]        line_idx;
  logic [8:0]        col_idx;
  logic              pix_strobe;
  logic              disp_blank;
  logic              mcu_win;
  logic              host_sel_n;
  logic [ADDR_W-1:0] host_addr;
  logic [DATA_W-1:0] host_wdata;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic              ram_we;
  logic [DATA_W-1:0] ram_rdata;
  logic [DATA_W-1:0] pixel_out;
  logic              grant;
  logic              grant_err;

  int errors = 0;
  int checks = 0;

  // model state
  logic              m_grant, m_we, m_err, m_pixq;
  logic [ADDR_W-1:0] m_haddr, m_scan;
  logic [DATA_W-1:0] m_hdata, m_pix;

  vram_arbiter i_vram_arbiter (
    .clk(clk), .rst_n(rst_n), .line_idx(line_idx), .col_idx(col_idx),
    .pix_strobe(pix_strobe), .disp_blank(disp_blank), .mcu_win(mcu_win),
    .host_sel_n(host_sel_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata), .pixel_out(pixel_out), .grant(grant),
    .grant_err(grant_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [ADDR_W-1:0] exp_scan(input int ln, input int cl);
    return ADDR_W'(ln * 320 + cl);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock: predict from current inputs, advance, compare
  task automatic step();
    logic n_grant, chg;
    n_grant = !host_sel_n && mcu_win;
    chg     = (host_addr != m_haddr) || (host_wdata != m_hdata);
    m_we    = n_grant && (!m_grant || chg);
    m_err   = !host_sel_n && !mcu_win;
    if (n_grant) begin
      m_haddr = host_addr;
      m_hdata = host_wdata;
    end
    m_grant = n_grant;
    m_scan  = exp_scan(int'(line_idx), int'(col_idx));
    if (m_pixq && !pix_strobe) m_pix = ram_rdata;
    m_pixq = pix_strobe;
    @(posedge clk);
    #1;
    chk("R3", "grant", int'(grant), int'(m_grant));
    if (m_grant) begin
      chk("R3", "ram_addr host", int'(ram_addr), int'(m_haddr));
      chk("R3", "ram_wdata host", int'(ram_wdata), int'(m_hdata));
    end else begin
      chk("R2", "ram_addr scan", int'(ram_addr), int'(m_scan));
      chk("R2", "ram_wdata scan", int'(ram_wdata), 0);
    end
    chk("R5", "ram_we", int'(ram_we), int'(m_we));
    chk("R4", "grant_err", int'(grant_err), int'(m_err));
    if (disp_blank) chk("R7", "pixel_out blank", int'(pixel_out), 0);
    else            chk("R6", "pixel_out", int'(pixel_out), int'(m_pix));
  endtask

  task automatic idle_inputs();
    line_idx = '0; col_idx = '0; pix_strobe = 1'b0; disp_blank = 1'b0;
    mcu_win = 1'b0; host_sel_n = 1'b1; host_addr = '0; host_wdata = '0;
    ram_rdata = '0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle_inputs();
    rst_n = 1'b0;
    host_sel_n = 1'b0; mcu_win = 1'b1; host_addr = 17'h1_2345; host_wdata = 8'hA5;
    ram_rdata = 8'h3C; pix_strobe = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    pix_strobe = 1'b0;
    #1;
    // R1: reset values despite active inputs
    chk("R1", "ram_addr", int'(ram_addr), 0);
    chk("R1", "ram_wdata", int'(ram_wdata), 0);
    chk("R1", "ram_we", int'(ram_we), 0);
    chk("R1", "grant", int'(grant), 0);
    chk("R1", "grant_err", int'(grant_err), 0);
    chk("R1", "pixel_out", int'(pixel_out), 0);

    idle_inputs();
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    m_grant = 0; m_we = 0; m_err = 0; m_pixq = 0;
    m_haddr = '0; m_hdata = '0; m_scan = '0; m_pix = '0;

    // R8 corners of the scan address
    line_idx = 8'd0;   col_idx = 9'd0;   step();
    chk("R8", "addr first pixel", int'(ram_addr), 0);
    line_idx = 8'd239; col_idx = 9'd319; step();
    chk("R8", "addr last pixel", int'(ram_addr), 76799);
    line_idx = 8'd1;   col_idx = 9'd5;   step();
    chk("R8", "addr line1 col5", int'(ram_addr), 325);

    // R3/R5 grant with write pulse, then hold with no repeat
    mcu_win = 1'b1; host_sel_n = 1'b0; host_addr = 17'h0_1234; host_wdata = 8'h5A;
    step();
    chk("R5", "we on grant", int'(ram_we), 1);
    step();
    chk("R5", "no we on hold", int'(ram_we), 0);
    host_wdata = 8'h5B; step();
    chk("R5", "we on new data", int'(ram_we), 1);
    host_addr = 17'h0_1235; step();
    chk("R5", "we on new addr", int'(ram_we), 1);
    step();

    // R4 select outside window ignored
    mcu_win = 1'b0; host_addr = 17'h1_0000; step();
    chk("R4", "err outside window", int'(grant_err), 1);
    chk("R4", "scan addr kept", int'(ram_addr), int'(exp_scan(1, 5)));
    host_sel_n = 1'b1; step();
    chk("R4", "err one cycle", int'(grant_err), 0);

    // R6 falling edge capture, rising edge no capture
    ram_rdata = 8'h77; pix_strobe = 1'b1; step();
    chk("R6", "no load on rise", int'(pixel_out), 0);
    pix_strobe = 1'b0; step();
    chk("R6", "load on fall", int'(pixel_out), 8'h77);
    ram_rdata = 8'h11; step();
    chk("R6", "hold while low", int'(pixel_out), 8'h77);
    // R7 blank forces zero
    disp_blank = 1'b1; #1;
    chk("R7", "blank zero", int'(pixel_out), 0);
    step();
    disp_blank = 1'b0; #1;
    chk("R7", "unblank restores", int'(pixel_out), 8'h77);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      line_idx   = 8'($urandom_range(0, 239));
      col_idx    = 9'($urandom_range(0, 319));
      pix_strobe = 1'($urandom_range(0, 1));
      disp_blank = ($urandom_range(0, 3) == 0);
      mcu_win    = ($urandom_range(0, 2) != 0);
      host_sel_n = ($urandom_range(0, 2) == 0);
      host_addr  = ADDR_W'($urandom_range(0, 3));
      host_wdata = DATA_W'($urandom_range(0, 3));
      ram_rdata  = DATA_W'($urandom_range(0, 255));
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule